// File: doc/BRIEF.md
# Low-Speed Oscillator Controller

This block manages two slow clock sources: a 32.768 kHz crystal path and an internal 32 kHz RC path. Software writes a small register set to switch each source on or off, to set the crystal's two-bit drive level, to choose bypass mode, and to set the startup delay. In bypass mode an external square clock of up to 1 MHz replaces the crystal oscillator on the crystal path. Each source's raw clock is passed downstream only after its ready flag is set. A glitch-free, latch-based gate blocks the clock until then.

Oscillator settling is not modelled in analog form. Each source runs a counter in its own clock domain. After the source is enabled, the counter waits a programmed number of raw source cycles and then marks the source stable. That stable mark crosses a two-flop synchronizer into the system clock domain and becomes the ready flag. A rising ready flag sets a pending bit for its source. The interrupt line is the OR of all pending bits whose enable bit is set.

Writes are accepted on the system clock. The rules on which fields may change while the crystal runs are applied at the moment of the write.

Top module: `lsosc_ctrl`

## Requirements
- R1: After reset both sources are off, the drive level reads 00, bypass reads 0, both ready flags and the interrupt are low, and both gated clocks stay low.
- R2: Register 0 (control) holds the crystal enable in bit 0 and the RC enable in bit 1. Each enable controls only its own source.
- R3: Control bits 4:3 hold the crystal drive level. While the crystal enable is 1 before a write, a write that would raise the level leaves it unchanged, and a write that lowers or keeps it is taken.
- R4: While the crystal enable is 0, any drive level may be written, including a higher one.
- R5: Control bit 2 selects bypass. It is taken only when the crystal enable is 0 before the write, and it is ignored while the crystal runs.
- R6: A source's ready flag rises no sooner than the startup count (register 3, all 8 bits) and no later than that count plus 6 raw source clock cycles after its enable is written.
- R7: A source's gated clock stays low while its ready flag is low. Once the flag is set, the gated clock follows the source clock.
- R8: Clearing a source's enable drops its ready flag within two system clock cycles, and its gated clock then stops.
- R9: With bypass set, the crystal path's gated clock follows the external clock input in place of the crystal input.
- R10: A rising ready flag sets that source's pending bit. Writing 1 to bit 0 (crystal) or bit 1 (RC) of register 2 clears the pending bit. The interrupt is the OR of the pending bits masked by the enables in register 1 (bit 0 crystal, bit 1 RC), and it is registered.
- R11: A pending bit whose interrupt enable is 0 does not drive the interrupt, and the bit is kept so that setting the enable later raises the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control, 1 interrupt enable, 2 pending clear, 3 startup count |
| wr_data | input | 8 | Write data |
| xtal_clk_in | input | 1 | Raw crystal oscillator clock |
| ext_clk_in | input | 1 | External clock used in bypass mode |
| rc_clk_in | input | 1 | Raw RC oscillator clock |
| xtal_gclk | output | 1 | Gated crystal-path clock |
| rc_gclk | output | 1 | Gated RC clock |
| xtal_ready | output | 1 | Crystal-path ready flag |
| rc_ready | output | 1 | RC ready flag |
| drive_o | output | 2 | Current crystal drive level |
| bypass_o | output | 1 | Current bypass selection |
| irq | output | 1 | Combined ready interrupt |

## Verification
Four properties are checked on every system clock cycle:
- the drive level never rises while the crystal stays enabled;
- bypass holds steady while the crystal runs;
- a ready flag stays low once its enable has been low for two cycles;
- a rising ready flag always leaves a pending bit set, and a masked interrupt stays quiet.

Some behaviours can only be shown by the bench scenarios. These are the startup delay measured in raw source edges, the gated clock staying silent before ready and stopping after disable, and the change of edge rate when bypass switches the crystal path to the external input.

// File: rtl/lsosc_pkg.sv
package lsosc_pkg;
  localparam int NSRC   = 2;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 8;
  localparam int ADDR_W = 2;
  localparam int SRC_XTAL = 0;
  localparam int SRC_RC   = 1;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL  = 2'd0,
    REG_IE    = 2'd1,
    REG_CLR   = 2'd2,
    REG_START = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/lsosc_regs.sv
module lsosc_regs
  import lsosc_pkg::*;
#(
  parameter logic [CNT_W-1:0] START_DEF = 8'd8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NSRC-1:0]   rdy_i,
  output logic [NSRC-1:0]   en_o,
  output logic [1:0]        drive_o,
  output logic              bypass_o,
  output logic [CNT_W-1:0]  limit_o,
  output logic              irq_o
);
  logic [NSRC-1:0] ie_q, pend_q, rdy_d, clr_v;
  logic [1:0]      drive_req;

  assign drive_req = wr_data[4:3];

  always_comb begin
    clr_v = '0;
    if (wr_en && wr_addr == REG_CLR) clr_v = wr_data[NSRC-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_o     <= '0;
      drive_o  <= 2'b00;
      bypass_o <= 1'b0;
      limit_o  <= START_DEF;
      ie_q     <= '0;
      pend_q   <= '0;
      rdy_d    <= '0;
      irq_o    <= 1'b0;
    end else begin
      rdy_d  <= rdy_i;
      pend_q <= (pend_q & ~clr_v) | (rdy_i & ~rdy_d);
      irq_o  <= |(pend_q & ie_q);
      if (wr_en) begin
        case (wr_addr)
          REG_CTRL: begin
            en_o <= wr_data[NSRC-1:0];
            if (!(en_o[SRC_XTAL] && drive_req > drive_o)) drive_o <= drive_req;
            if (!en_o[SRC_XTAL]) bypass_o <= wr_data[2];
          end
          REG_IE:    ie_q    <= wr_data[NSRC-1:0];
          REG_START: limit_o <= wr_data[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  // R3
  drive_mono_chk: assert property (@(posedge clk) disable iff (rst)
    (en_o[SRC_XTAL] && $past(en_o[SRC_XTAL])) |-> (drive_o <= $past(drive_o)));

  // R5
  byp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (en_o[SRC_XTAL] && $past(en_o[SRC_XTAL])) |-> $stable(bypass_o));

  // R11
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (ie_q == '0 && $past(ie_q) == '0) |-> !irq_o);

  for (genvar g = 0; g < NSRC; g++) begin : g_pend_chk
    // R10
    pend_set_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(rdy_i[g]) |=> pend_q[g]);
  end
endmodule

// File: rtl/lsosc_src.sv
module lsosc_src
  import lsosc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             src_clk,
  output logic             rdy_o,
  output logic             gclk_o
);
  logic [1:0]       en_s;
  logic [CNT_W-1:0] cnt;
  logic             stable;
  logic [1:0]       stable_s;
  logic             gate_l;

  // source-domain startup counter
  always_ff @(posedge src_clk) begin
    if (rst) begin
      en_s   <= 2'b00;
      cnt    <= '0;
      stable <= 1'b0;
    end else begin
      en_s <= {en_s[0], en_i};
      if (!en_s[1]) begin
        cnt    <= '0;
        stable <= 1'b0;
      end else if (cnt >= limit_i) begin
        stable <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // back into the system domain
  always_ff @(posedge clk) begin
    if (rst) begin
      stable_s <= 2'b00;
      rdy_o    <= 1'b0;
    end else begin
      stable_s <= {stable_s[0], stable};
      rdy_o    <= en_i & stable_s[1];
    end
  end

  // glitch-free gate: enable only moves while the source clock is low
  always_latch begin
    if (!src_clk) gate_l <= rdy_o;
  end
  assign gclk_o = src_clk & gate_l;

  // R8
  rdy_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!en_i && !$past(en_i)) |-> !rdy_o);
endmodule

// File: rtl/lsosc_ctrl.sv
module lsosc_ctrl
  import lsosc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              xtal_clk_in,
  input  logic              ext_clk_in,
  input  logic              rc_clk_in,
  output logic              xtal_gclk,
  output logic              rc_gclk,
  output logic              xtal_ready,
  output logic              rc_ready,
  output logic [1:0]        drive_o,
  output logic              bypass_o,
  output logic              irq
);
  logic [NSRC-1:0]  en, rdy, gclk, raw_clk;
  logic [CNT_W-1:0] limit;

  assign raw_clk[SRC_XTAL] = bypass_o ? ext_clk_in : xtal_clk_in;
  assign raw_clk[SRC_RC]   = rc_clk_in;

  lsosc_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rdy_i    (rdy),
    .en_o     (en),
    .drive_o  (drive_o),
    .bypass_o (bypass_o),
    .limit_o  (limit),
    .irq_o    (irq)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    lsosc_src u_src (
      .clk     (clk),
      .rst     (rst),
      .en_i    (en[i]),
      .limit_i (limit),
      .src_clk (raw_clk[i]),
      .rdy_o   (rdy[i]),
      .gclk_o  (gclk[i])
    );
  end

  assign xtal_gclk  = gclk[SRC_XTAL];
  assign rc_gclk    = gclk[SRC_RC];
  assign xtal_ready = rdy[SRC_XTAL];
  assign rc_ready   = rdy[SRC_RC];
endmodule

// File: tb/test_lsosc_ctrl.sv
module test_lsosc_ctrl;
  logic clk = 0, rst = 1;
  logic wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic xtal_clk_in = 0, ext_clk_in = 0, rc_clk_in = 0;
  logic xtal_gclk, rc_gclk, xtal_ready, rc_ready, bypass_o, irq;
  logic [1:0] drive_o;

  int checks = 0, fails = 0;
  int xe_cnt = 0, ee_cnt = 0, re_cnt = 0;
  int xg_cnt = 0, rg_cnt = 0;
  logic [1:0] exp_on = 0, exp_drv = 0;
  logic exp_byp = 0;
  localparam int LIM = 6;

  lsosc_ctrl i_lsosc_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .xtal_clk_in(xtal_clk_in), .ext_clk_in(ext_clk_in), .rc_clk_in(rc_clk_in),
    .xtal_gclk(xtal_gclk), .rc_gclk(rc_gclk), .xtal_ready(xtal_ready),
    .rc_ready(rc_ready), .drive_o(drive_o), .bypass_o(bypass_o), .irq(irq)
  );

  initial forever #4  clk = ~clk;
  initial forever #20 xtal_clk_in = ~xtal_clk_in;
  initial forever #10 ext_clk_in = ~ext_clk_in;
  initial forever #28 rc_clk_in = ~rc_clk_in;

  always @(posedge xtal_clk_in) xe_cnt++;
  always @(posedge ext_clk_in)  ee_cnt++;
  always @(posedge rc_clk_in)   re_cnt++;
  always @(posedge xtal_gclk)   xg_cnt++;
  always @(posedge rc_gclk)     rg_cnt++;

  function automatic logic [1:0] next_drive(logic on, logic [1:0] cur, logic [1:0] req);
    return (on && req > cur) ? cur : req;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wr_ctrl(logic [1:0] on, logic byp, logic [1:0] drv);
    exp_drv = next_drive(exp_on[0], exp_drv, drv);
    if (!exp_on[0]) exp_byp = byp;
    exp_on = on;
    wr(2'd0, {3'b000, drv, byp, on});
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // enable a source, then check delay, gating before ready and running after
  task automatic bring_up(int idx, logic byp, string req_t);
    int edges, gate_bad, lim_hi, g0;
    gate_bad = 0;
    wr_ctrl(idx == 0 ? 2'b01 : 2'b10, byp, exp_drv);
    if (idx == 0) begin xe_cnt = 0; ee_cnt = 0; end else re_cnt = 0;
    for (int k = 0; k < 2000; k++) begin
      if ((idx == 0 ? xtal_ready : rc_ready)) break;
      if ((idx == 0 ? xtal_gclk : rc_gclk)) gate_bad++;
      @(negedge clk);
    end
    edges = (idx == 0) ? (byp ? ee_cnt : xe_cnt) : re_cnt;
    lim_hi = LIM + 6;
    chk(edges >= LIM - 1 && edges <= lim_hi, {"R6 ", req_t, " startup edges"}, edges, LIM);
    chk(gate_bad == 0, {"R7 ", req_t, " gated clock before ready"}, gate_bad, 0);
    g0 = (idx == 0) ? xg_cnt : rg_cnt;
    idle(80);
    edges = ((idx == 0) ? xg_cnt : rg_cnt) - g0;
    if (idx == 1)
      chk(edges >= 9 && edges <= 13, {"R7 ", req_t, " gated edges"}, edges, 11);
    else if (byp)
      chk(edges >= 29 && edges <= 33, {"R9 ", req_t, " bypass gated edges"}, edges, 32);
    else
      chk(edges >= 14 && edges <= 18, {"R7 ", req_t, " gated edges"}, edges, 16);
  endtask

  task automatic shut_down(int idx, string req_t);
    int g0;
    wr_ctrl(2'b00, exp_byp, exp_drv);
    idle(1);
    chk((idx == 0 ? xtal_ready : rc_ready) == 0, {"R8 ", req_t, " ready cleared"},
        int'(idx == 0 ? xtal_ready : rc_ready), 0);
    idle(4);
    g0 = (idx == 0) ? xg_cnt : rg_cnt;
    idle(40);
    chk(((idx == 0) ? xg_cnt : rg_cnt) == g0, {"R8 ", req_t, " gated clock stopped"},
        ((idx == 0) ? xg_cnt : rg_cnt) - g0, 0);
    idle(20);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    report();
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (10) @(negedge clk);
    rst = 0;
    idle(2);
    // R1 reset state
    chk(drive_o == 2'b00, "R1 drive", drive_o, 0);
    chk(bypass_o == 0, "R1 bypass", bypass_o, 0);
    chk(!xtal_ready && !rc_ready, "R1 ready flags", {xtal_ready, rc_ready}, 0);
    chk(irq == 0, "R1 irq", irq, 0);
    begin
      int gx, gr;
      gx = xg_cnt; gr = rg_cnt;
      idle(30);
      chk(xg_cnt == gx && rg_cnt == gr, "R1 gated clocks quiet", xg_cnt - gx + rg_cnt - gr, 0);
    end

    wr(2'd3, 8'(LIM));

    // R4 raise while off
    wr_ctrl(2'b00, 0, 2'b11);
    idle(1);
    chk(drive_o == 2'b11, "R4 raise while off", drive_o, 3);

    // R2 RC alone
    wr(2'd1, 8'b10);
    bring_up(1, 0, "rc");
    chk(!xtal_ready, "R2 crystal stays off", xtal_ready, 0);
    chk(irq == 1, "R10 rc irq", irq, 1);
    wr(2'd2, 8'b10);
    idle(2);
    chk(irq == 0, "R10 rc clear", irq, 0);
    shut_down(1, "rc");

    // crystal with drive rules
    wr(2'd1, 8'b00);
    bring_up(0, 0, "xtal");
    chk(irq == 0, "R11 masked irq", irq, 0);
    wr(2'd1, 8'b01);
    idle(2);
    chk(irq == 1, "R11 pending kept", irq, 1);
    wr(2'd2, 8'b01);
    idle(2);
    chk(irq == 0, "R10 xtal clear", irq, 0);
    wr_ctrl(2'b01, 0, 2'b01);
    idle(1);
    chk(drive_o == 2'b01, "R3 lower while on", drive_o, 1);
    wr_ctrl(2'b01, 0, 2'b10);
    idle(1);
    chk(drive_o == 2'b01, "R3 raise ignored", drive_o, 1);
    wr_ctrl(2'b01, 1, 2'b00);
    idle(1);
    chk(bypass_o == 0, "R5 bypass ignored while on", bypass_o, 0);
    chk(drive_o == 2'b00, "R3 lower to 00", drive_o, 0);
    chk(xtal_ready == 1, "R2 crystal still ready", xtal_ready, 1);

    // random control writes against the model
    wr(2'd1, 8'b00);
    for (int n = 0; n < 40; n++) begin
      logic [7:0] d;
      d = 8'($urandom);
      wr_ctrl(d[1:0], d[2], d[4:3]);
      idle(1);
      chk(drive_o == exp_drv, "R3 random drive", drive_o, exp_drv);
      chk(bypass_o == exp_byp, "R5 random bypass", bypass_o, exp_byp);
      idle(int'($urandom_range(0, 6)));
    end
    wr_ctrl(2'b00, exp_byp, exp_drv);
    idle(60);
    wr(2'd2, 8'b11);

    // bypass path
    wr_ctrl(2'b00, 1, 2'b00);
    idle(1);
    chk(bypass_o == 1, "R5 bypass taken while off", bypass_o, 1);
    wr(2'd1, 8'b01);
    bring_up(0, 1, "bypass");
    chk(irq == 1, "R10 bypass irq", irq, 1);
    shut_down(0, "bypass");
    wr(2'd2, 8'b01);
    idle(2);
    chk(irq == 0, "R10 final clear", irq, 0);
    report();
  end
endmodule